// File: doc/BRIEF.md
# Prefetching Texture Cache Pipeline

This block is the read-only front end of a texture-style cache. The tag check is split from data delivery. Every accepted access pushes an entry into an in-order fragment queue, whether its tag hit or missed. A miss allocates its line at once and queues a memory fetch. It also reserves a reorder-buffer slot, and the fetch carries that slot number. Memory may answer fetches in any order by naming the slot. The reorder buffer writes returning blocks into the cache strictly in fetch order. The oldest fragment leaves for the result queue only once its line holds the block it expects.

The cache is direct-mapped. A tag hit only means that the block is present or already on its way, so a tag hit is never reported as ready data. The requester learns the outcome in the same cycle: pending hit, miss or refusal. It collects completed accesses, in acceptance order, from a ready/valid result port. Texel data and the memory itself are outside the block. A fill is a notification carrying the slot index.

Top module: `tex_prefetch_cache`

## Requirements
- R1: After reset there is no result and no memory request, and every line is invalid, so the first access to any block misses.
- R2: `acc_resp` encodes 0 with no access, 1 for an accepted access whose tag matched, 2 for an accepted miss and 3 for a refused access. Value 1 says nothing about whether data is present.
- R3: The block address is `acc_addr >> OFF_W`, and the line index is its low log2(SETS) bits. The tag is the whole block address. An accepted miss writes the tag at once, so a later access to the same block reports 1 even before its fill has returned.
- R4: An access is refused if the fragment queue is full, or if it misses while the request queue or the reorder buffer is full. A refused access allocates no tag, issues no fetch and produces no result.
- R5: Each accepted miss issues exactly one fetch, in acceptance order. The fetch address is `acc_addr` with its low OFF_W bits cleared, and it carries the reserved slot. `mem_req_addr` and `mem_req_valid` hold while `mem_req_ready` is low.
- R6: Fills may arrive in any order, naming a slot that was issued and has not yet been filled. Blocks enter the cache only in fetch order, so a later fill does not release results held by an earlier missing fill.
- R7: Results leave in acceptance order and carry the access's `acc_id` and a miss flag equal to (`acc_resp` == 2). A fragment does not retire before its line holds its block.
- R8: A miss to another block of the same line replaces the tag, so a following access to the evicted block misses again.
- R9: While `res_ready` is low, `res_valid` and `res_id` hold. A full result queue stalls retirement and no result is lost.
- R10: An access that hits a line whose data is already present completes without issuing any fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_id | input | ID_W | Requester tag returned with the result |
| acc_resp | output | 2 | Same-cycle outcome: 0 none, 1 pending hit, 2 miss, 3 refused |
| mem_req_valid | output | 1 | Fetch waiting for memory |
| mem_req_ready | input | 1 | Memory takes the fetch |
| mem_req_addr | output | ADDR_W | Block-aligned fetch address |
| mem_req_slot | output | log2(ROB_DEPTH) | Reorder slot reserved for the fetch |
| fill_valid | input | 1 | A fetch has returned |
| fill_slot | input | log2(ROB_DEPTH) | Slot of the returned fetch |
| res_valid | output | 1 | Completed access available |
| res_ready | input | 1 | Requester takes the result |
| res_id | output | ID_W | Id of the completed access |
| res_miss | output | 1 | Completed access had missed |

## Verification
The bench fills the reorder buffer with stalled misses and then fills the fragment queue with pending hits. A design that checked the wrong queue would accept a fifth miss or a ninth fragment and overflow. It then returns fills in reverse order and checks that nothing is released until the oldest fill lands. A design that wrote blocks in fill order would deliver results out of order, or would let a hit read a line that is still empty. It also checks that a refused miss left no tag behind, and that an evicted block misses again. A design that kept the old tag would report a stale hit, and its fragment would wait forever. Random traffic with random back-pressure on all three handshakes is then checked against a direct-mapped tag model and an in-order scoreboard.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic [1:0] {
    RESP_NONE     = 2'd0,
    RESP_HIT_PEND = 2'd1,
    RESP_MISS     = 2'd2,
    RESP_REFUSE   = 2'd3
  } resp_e;
endpackage

// File: rtl/tpc_fifo.sv
// Circular queue with write and read pointers and an occupancy count.
// DEPTH must be a power of two. Storage has no reset, so it can map to RAM.
module tpc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [W-1:0]  mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign dout  = mem[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> !full); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R7
endmodule

// File: rtl/tpc_rob.sv
// Reorder buffer: slots are reserved in fetch order and marked ready by fill
// in any order. The head slot retires only once it is ready.
module tpc_rob #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 3,
  parameter int BLK_W  = 12,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [LINE_W-1:0] push_line,
  input  logic [BLK_W-1:0]  push_blk,
  output logic [AW-1:0]     push_slot,
  output logic              full,
  input  logic              fill_valid,
  input  logic [AW-1:0]     fill_slot,
  input  logic              pop,
  output logic              empty,
  output logic              head_ready,
  output logic [LINE_W-1:0] head_line,
  output logic [BLK_W-1:0]  head_blk
);
  logic [AW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;
  logic [DEPTH-1:0]  rdy;
  logic [LINE_W-1:0] line_m [DEPTH];
  logic [BLK_W-1:0]  blk_m  [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      rdy <= '0;
    end else begin
      if (push) begin
        wp      <= wp + 1'b1;
        rdy[wp] <= 1'b0;
      end
      if (pop) begin
        rp      <= rp + 1'b1;
        rdy[rp] <= 1'b0;
      end
      if (fill_valid) rdy[fill_slot] <= 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      line_m[wp] <= push_line;
      blk_m[wp]  <= push_blk;
    end
  end

  assign push_slot  = wp;
  assign full       = (cnt == CW'(DEPTH));
  assign empty      = (cnt == '0);
  assign head_ready = !empty && rdy[rp];
  assign head_line  = line_m[rp];
  assign head_blk   = blk_m[rp];

  logic [AW-1:0] fill_dist;
  assign fill_dist = fill_slot - rp;

  AST_FILL_PENDING_SLOT: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> ({1'b0, fill_dist} < cnt) && !rdy[fill_slot]); // R6
  AST_ROB_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> !full); // R4
endmodule

// File: rtl/tpc_tag_store.sv
// Direct-mapped tag array (written on miss) plus the line-content array
// (written when the reorder buffer retires a block).
module tpc_tag_store #(
  parameter int SETS  = 8,
  parameter int BLK_W = 12,
  localparam int LW   = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BLK_W-1:0] look_blk,
  output logic             look_hit,
  input  logic             alloc_en,
  input  logic [LW-1:0]    chk_line,
  input  logic [BLK_W-1:0] chk_blk,
  output logic             chk_present,
  input  logic             commit_en,
  input  logic [LW-1:0]    commit_line,
  input  logic [BLK_W-1:0] commit_blk
);
  logic [SETS-1:0]  tag_v, dat_v;
  logic [BLK_W-1:0] tag_m [SETS];
  logic [BLK_W-1:0] dat_m [SETS];
  logic [LW-1:0]    look_line;

  assign look_line = look_blk[LW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_v <= '0;
      dat_v <= '0;
    end else begin
      if (alloc_en)  tag_v[look_line]   <= 1'b1;
      if (commit_en) dat_v[commit_line] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en)  tag_m[look_line]   <= look_blk;
    if (commit_en) dat_m[commit_line] <= commit_blk;
  end

  assign look_hit    = tag_v[look_line] && (tag_m[look_line] == look_blk);
  assign chk_present = dat_v[chk_line] && (dat_m[chk_line] == chk_blk);

  AST_ALLOC_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> !look_hit); // R3
  AST_COMMIT_TO_RESERVED: assert property (@(posedge clk) disable iff (rst)
    commit_en |-> tag_v[commit_line]); // R6
endmodule

// File: rtl/tex_prefetch_cache.sv
module tex_prefetch_cache
  import tpc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 4,
  parameter int SETS       = 8,
  parameter int ID_W       = 8,
  parameter int FRAG_DEPTH = 8,
  parameter int REQ_DEPTH  = 4,
  parameter int ROB_DEPTH  = 4,
  parameter int RES_DEPTH  = 4,
  localparam int SLOT_W    = $clog2(ROB_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ID_W-1:0]   acc_id,
  output logic [1:0]        acc_resp,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [SLOT_W-1:0] mem_req_slot,
  input  logic              fill_valid,
  input  logic [SLOT_W-1:0] fill_slot,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ID_W-1:0]   res_id,
  output logic              res_miss
);
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int LINE_W = $clog2(SETS);
  localparam int FRAG_W = ID_W + LINE_W + BLK_W + 1;
  localparam int REQ_W  = BLK_W + SLOT_W;
  localparam int RES_W  = ID_W + 1;

  // access decode and acceptance
  logic [BLK_W-1:0]  acc_blk;
  logic [LINE_W-1:0] acc_line;
  logic              tag_hit, refuse, frag_push, miss_push;
  logic              frag_full, frag_empty, req_full, req_empty;
  logic              rob_full, rob_empty, res_full, res_empty;
  logic [SLOT_W-1:0] rob_slot;
  resp_e             resp;

  assign acc_blk  = acc_addr[ADDR_W-1:OFF_W];
  assign acc_line = acc_blk[LINE_W-1:0];

  assign refuse    = frag_full || (!tag_hit && (req_full || rob_full));
  assign frag_push = acc_valid && !refuse;
  assign miss_push = frag_push && !tag_hit;

  always_comb begin
    resp = RESP_NONE;
    if (acc_valid) begin
      if (refuse)       resp = RESP_REFUSE;
      else if (tag_hit) resp = RESP_HIT_PEND;
      else              resp = RESP_MISS;
    end
  end
  assign acc_resp = resp;

  // fragment queue: {id, line, block, miss}
  logic [FRAG_W-1:0] frag_din, frag_dout;
  logic [ID_W-1:0]   fr_id;
  logic [LINE_W-1:0] fr_line;
  logic [BLK_W-1:0]  fr_blk;
  logic              fr_miss;
  logic              frag_pop;

  assign frag_din = {acc_id, acc_line, acc_blk, !tag_hit};
  assign {fr_id, fr_line, fr_blk, fr_miss} = frag_dout;

  tpc_fifo #(.W(FRAG_W), .DEPTH(FRAG_DEPTH)) u_frag (
    .clk(clk), .rst(rst), .push(frag_push), .din(frag_din), .pop(frag_pop),
    .dout(frag_dout), .full(frag_full), .empty(frag_empty));

  // request queue toward memory: {block, slot}
  logic [REQ_W-1:0]  req_dout;
  logic [BLK_W-1:0]  rq_blk;
  logic [SLOT_W-1:0] rq_slot;
  logic              req_pop;

  assign {rq_blk, rq_slot} = req_dout;
  assign mem_req_valid = !req_empty;
  assign mem_req_addr  = {rq_blk, {OFF_W{1'b0}}};
  assign mem_req_slot  = rq_slot;
  assign req_pop       = mem_req_valid && mem_req_ready;

  tpc_fifo #(.W(REQ_W), .DEPTH(REQ_DEPTH)) u_req (
    .clk(clk), .rst(rst), .push(miss_push), .din({acc_blk, rob_slot}),
    .pop(req_pop), .dout(req_dout), .full(req_full), .empty(req_empty));

  // reorder buffer
  logic              rob_pop, rob_head_ready;
  logic [LINE_W-1:0] rob_head_line;
  logic [BLK_W-1:0]  rob_head_blk;

  tpc_rob #(.DEPTH(ROB_DEPTH), .LINE_W(LINE_W), .BLK_W(BLK_W)) u_rob (
    .clk(clk), .rst(rst), .push(miss_push), .push_line(acc_line),
    .push_blk(acc_blk), .push_slot(rob_slot), .full(rob_full),
    .fill_valid(fill_valid), .fill_slot(fill_slot), .pop(rob_pop),
    .empty(rob_empty), .head_ready(rob_head_ready),
    .head_line(rob_head_line), .head_blk(rob_head_blk));

  // tags and line contents
  logic line_present;

  tpc_tag_store #(.SETS(SETS), .BLK_W(BLK_W)) u_tags (
    .clk(clk), .rst(rst), .look_blk(acc_blk), .look_hit(tag_hit),
    .alloc_en(miss_push), .chk_line(fr_line), .chk_blk(fr_blk),
    .chk_present(line_present), .commit_en(rob_pop),
    .commit_line(rob_head_line), .commit_blk(rob_head_blk));

  // retirement: a missing fragment at the head commits its block and
  // retires in the same cycle; a hit fragment waits for its block.
  logic can_retire;
  assign can_retire = !frag_empty && !res_full &&
                      (fr_miss ? (!rob_empty && rob_head_ready) : line_present);
  assign frag_pop = can_retire;
  assign rob_pop  = can_retire && fr_miss;

  // result queue: {id, miss}
  logic [RES_W-1:0] res_dout;
  logic             res_pop;

  assign res_pop = res_valid && res_ready;

  tpc_fifo #(.W(RES_W), .DEPTH(RES_DEPTH)) u_res (
    .clk(clk), .rst(rst), .push(can_retire), .din({fr_id, fr_miss}),
    .pop(res_pop), .dout(res_dout), .full(res_full), .empty(res_empty));

  assign res_valid          = !res_empty;
  assign {res_id, res_miss} = res_dout;

  AST_RETIRE_MATCHES_ROB: assert property (@(posedge clk) disable iff (rst)
    rob_pop |-> (rob_head_blk == fr_blk) && (rob_head_line == fr_line)); // R6
  AST_REFUSE_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    (acc_resp == 2'd3) |-> !frag_push && !miss_push); // R4
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(res_id)); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R5
  AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (acc_resp == 2'd1) |-> !miss_push); // R10
endmodule

// File: tb/tb_tex_prefetch_cache.sv
`timescale 1ns/1ps
module tb_tex_prefetch_cache;
  localparam int ADDR_W = 16;
  localparam int OFF_W  = 4;
  localparam int SETS   = 8;
  localparam int ID_W   = 8;
  localparam int SW     = 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              acc_valid;
  logic [ADDR_W-1:0] acc_addr;
  logic [ID_W-1:0]   acc_id;
  logic [1:0]        acc_resp;
  logic              mem_req_valid, mem_req_ready;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [SW-1:0]     mem_req_slot;
  logic              fill_valid;
  logic [SW-1:0]     fill_slot;
  logic              res_valid, res_ready, res_miss;
  logic [ID_W-1:0]   res_id;

  always #2.5 clk = ~clk;

  tex_prefetch_cache dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_id(acc_id), .acc_resp(acc_resp), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_slot(mem_req_slot), .fill_valid(fill_valid),
    .fill_slot(fill_slot), .res_valid(res_valid), .res_ready(res_ready),
    .res_id(res_id), .res_miss(res_miss));

  int checks = 0, fails = 0;
  // direct-mapped tag model
  bit        mv [SETS];
  int        mt [SETS];
  // in-order result scoreboard
  int        exp_id [4096];
  bit        exp_miss [4096];
  int        sb_wr = 0, sb_rd = 0;
  // expected fetch addresses
  int        exp_req [4096];
  int        rq_wr = 0, rq_rd = 0;
  // issued, unfilled slots
  int        pend [16];
  int        pend_n = 0;
  int        next_id = 0;
  bit        auto_fill = 0;
  int        man_fill = -1;
  int        rr_pct = 100, mr_pct = 100;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic bit model_hit(int a);
    int b = a >> OFF_W;
    return mv[b % SETS] && (mt[b % SETS] == b);
  endfunction

  task automatic cyc(bit v, int a, output int resp);
    bit eh;
    int b;
    @(negedge clk);
    acc_valid     = v;
    acc_addr      = ADDR_W'(a);
    acc_id        = ID_W'(next_id);
    res_ready     = ($urandom % 100) < rr_pct;
    mem_req_ready = ($urandom % 100) < mr_pct;
    fill_valid    = 1'b0;
    fill_slot     = '0;
    if (man_fill >= 0) begin
      for (int k = 0; k < pend_n; k++)
        if (pend[k] == man_fill) begin
          fill_valid = 1'b1;
          fill_slot  = SW'(man_fill);
          for (int j = k; j < pend_n - 1; j++) pend[j] = pend[j+1];
          pend_n--;
          break;
        end
      man_fill = -1;
    end else if (auto_fill && pend_n > 0 && ($urandom % 3) == 0) begin
      int k = $urandom % pend_n;
      fill_valid = 1'b1;
      fill_slot  = SW'(pend[k]);
      for (int j = k; j < pend_n - 1; j++) pend[j] = pend[j+1];
      pend_n--;
    end
    #1;
    resp = int'(acc_resp);
    eh = model_hit(a);
    if (!v) chk(acc_resp == 2'd0, "R2 idle response", resp, 0);
    else if (resp != 3) begin
      chk((resp == 1) == eh, "R3 hit/miss classification", resp, eh ? 1 : 2);
      exp_id[sb_wr % 4096]   = next_id % 256;
      exp_miss[sb_wr % 4096] = (resp == 2);
      sb_wr++;
      next_id++;
      if (resp == 2) begin
        b = a >> OFF_W;
        mv[b % SETS] = 1;
        mt[b % SETS] = b;
        exp_req[rq_wr % 4096] = b << OFF_W;
        rq_wr++;
      end
    end
    if (mem_req_valid && mem_req_ready) begin
      if (rq_rd < rq_wr)
        chk(int'(mem_req_addr) == exp_req[rq_rd % 4096], "R5 fetch address",
            int'(mem_req_addr), exp_req[rq_rd % 4096]);
      else chk(0, "R5 unexpected fetch", int'(mem_req_addr), -1);
      rq_rd++;
      pend[pend_n] = int'(mem_req_slot);
      pend_n++;
    end
    if (res_valid && res_ready) begin
      if (sb_rd < sb_wr) begin
        chk(int'(res_id) == exp_id[sb_rd % 4096], "R7 result order id",
            int'(res_id), exp_id[sb_rd % 4096]);
        chk(res_miss == exp_miss[sb_rd % 4096], "R7 result miss flag",
            int'(res_miss), int'(exp_miss[sb_rd % 4096]));
      end else chk(0, "R7 unexpected result", int'(res_id), -1);
      sb_rd++;
    end
  endtask

  task automatic idle(int n);
    int r;
    for (int i = 0; i < n; i++) cyc(0, 0, r);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int r, held, nreq;
    for (int s = 0; s < SETS; s++) begin mv[s] = 0; mt[s] = 0; end
    rst = 1; acc_valid = 0; acc_addr = '0; acc_id = '0;
    res_ready = 0; mem_req_ready = 0; fill_valid = 0; fill_slot = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk(!res_valid, "R1 reset result", int'(res_valid), 0);
    chk(!mem_req_valid, "R1 reset fetch", int'(mem_req_valid), 0);

    // directed: stall fills and results
    rr_pct = 0; mr_pct = 100;
    for (int i = 0; i < 4; i++) begin
      cyc(1, 'h100 + i * 'h10, r);
      chk(r == 2, "R1 first access misses", r, 2);
    end
    cyc(1, 'h140, r);
    chk(r == 3, "R4 refuse on full reorder buffer", r, 3);
    cyc(1, 'h105, r);
    chk(r == 1, "R3 pending hit before fill", r, 1);
    for (int i = 1; i < 4; i++) cyc(1, 'h100 + i * 'h10, r);
    cyc(1, 'h100, r);
    chk(r == 3, "R4 refuse on full fragment queue", r, 3);
    idle(4);
    chk(!res_valid, "R7 no result before data", int'(res_valid), 0);
    chk(pend_n == 4, "R5 four fetches issued", pend_n, 4);
    man_fill = pend[3]; idle(1);
    idle(3);
    chk(!res_valid, "R6 later fill releases nothing", int'(res_valid), 0);
    man_fill = pend[2]; idle(1);
    man_fill = pend[1]; idle(1);
    man_fill = pend[0]; idle(1);
    idle(4);
    chk(res_valid, "R9 result queued", int'(res_valid), 1);
    held = int'(res_id);
    idle(3);
    chk(res_valid && int'(res_id) == held, "R9 result held", int'(res_id), held);
    rr_pct = 100;
    idle(16);
    chk(sb_rd == sb_wr, "R7 all results delivered", sb_rd, sb_wr);

    // hit with data present needs no fetch
    nreq = rq_rd;
    cyc(1, 'h10c, r);
    chk(r == 1, "R10 hit on filled line", r, 1);
    idle(6);
    chk(rq_rd == nreq && !mem_req_valid, "R10 no fetch for hit", rq_rd, nreq);
    chk(sb_rd == sb_wr, "R10 hit completed", sb_rd, sb_wr);

    // eviction and refused-miss side effects
    auto_fill = 1;
    cyc(1, 'h180, r);
    chk(r == 2, "R8 conflicting block misses", r, 2);
    cyc(1, 'h100, r);
    chk(r == 2, "R8 evicted block misses again", r, 2);
    cyc(1, 'h140, r);
    chk(r == 2, "R4 refused miss left no tag", r, 2);
    idle(40);
    chk(sb_rd == sb_wr, "R6 eviction traffic drained", sb_rd, sb_wr);

    // random traffic with back-pressure everywhere
    rr_pct = 70; mr_pct = 75;
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom % 4) != 0;
      int a = (('h20 + ($urandom % 16)) << OFF_W) | ($urandom % 16);
      cyc(v, a, r);
      if (v) chk(r != 0, "R2 access always answered", r, 1);
    end
    rr_pct = 100; mr_pct = 100;
    for (int i = 0; i < 400 && (sb_rd < sb_wr || pend_n > 0); i++) idle(1);
    chk(sb_rd == sb_wr, "R7 random results drained", sb_rd, sb_wr);
    chk(rq_rd == rq_wr, "R5 random fetches all issued", rq_rd, rq_wr);
    finish_run();
  end
endmodule